// File: doc/BRIEF.md
# Prescaled Interval Timer

This block holds a small bank of up-counting timer channels behind one synchronous register port. Each channel counts pulses of its own tick-enable input, optionally slowed by a power-of-two prescaler. In free-running mode it simply wraps. In interval mode it returns to zero at a programmed limit and raises an interval flag, which can drive a level interrupt. Software arms a channel by loading the limit and then writing counter control. That write clears the halt bit and restarts the count from zero, so the new interval is timed from its start. A handler acknowledges the interrupt by reading the status register, and the read clears the flag.

The number of channels, the counter width (16 or 32 bits), the address width and the data width are parameters. Channel `c` uses the same register layout as channel 0, moved up by `4*c` bytes. The tick-enable input stands in for whichever input clock the system selects. The source-select bit is stored and read back only.

Top module: `tmr_unit`

## Requirements
- R1: After reset every channel reads clock control 0, counter control 0x1 (halted, free-running), count 0, interval 0, status 0 and enable 0, and every irq bit is low.
- R2: Channel c's registers sit at base offsets clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and enable 0x60, each plus 4*c. Clock control keeps bit 0 (prescaler on), bits 4:1 (code N) and bit 5 (source select), and reads bits above 5 as 0. Enable keeps only bit 0.
- R3: While counter control bit 0 is 1, the count holds its value whatever the tick input does.
- R4: With counter control bit 1 at 0 (free-running), the count rises by one per advance, wraps from all-ones to zero, and never sets the status flag.
- R5: With the prescaler off, every tick advances the count. With it on, the count advances once per 2^(N+1) ticks.
- R6: With counter control bit 1 at 1 (interval mode), an advance taken while the count equals the interval value sets the count to 0 and sets status bit 0.
- R7: A counter-control write with bit 4 set forces the count and the prescaler divider to zero. The same write also applies bits 0 and 1. Bit 4 reads back as 0.
- R8: Read data is valid the cycle after the read strobe. A status read returns the pending flag and clears it.
- R9: A flag that sets in the same cycle as a status read stays pending, and that read returns the old value.
- R10: irq of a channel is high exactly while its status bit 0 and enable bit 0 are both 1. Writing 0 to enable drops irq on the next cycle.
- R11: Writes to the count and status addresses change nothing. A read of an unmapped address returns 0.
- R12: Any clock control write clears the prescaler divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register access |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Registered read data |
| tickEn | input | NUM_CH | Per-channel input tick |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
A register write takes effect at the clock edge that samples the write strobe, and the count moves at the edge that samples a tick. The interval flag, and with it irq, rises at that same edge. Read data appears in the cycle after the edge that samples the read strobe. The bench drives every input on the falling edge and queues the expected value of each read. A monitor compares each read one full cycle later, on the next falling edge. Interrupt levels are checked on the falling edge right after the write or tick that changed them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_CLK  = 'h00;
  localparam int OFF_CNT  = 'h0C;
  localparam int OFF_VAL  = 'h18;
  localparam int OFF_INTV = 'h24;
  localparam int OFF_STAT = 'h54;
  localparam int OFF_EN   = 'h60;
  localparam int CH_STRIDE = 4;

  localparam int BIT_HALT    = 0;
  localparam int BIT_MODE    = 1;
  localparam int BIT_RESTART = 4;
  localparam int PRE_W       = 4;
  localparam int CLK_CTL_W   = PRE_W + 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CLK, SEL_CNT, SEL_VAL, SEL_INTV, SEL_STAT, SEL_EN
  } rdSel_e;

  typedef struct packed {
    logic   wrClk;
    logic   wrCnt;
    logic   wrIntv;
    logic   wrIrqEn;
    logic   rdStat;
    rdSel_e sel;
  } chanStb_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             clear,
  input  logic             bypass,
  input  logic [PRE_W-1:0] code,
  output logic             adv
);
  localparam int DIV_W = 2 ** PRE_W;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] limit;
  logic             atLimit;

  // limit = 2^(code+1)-1, built as a thermometer mask
  always_comb begin
    for (int b = 0; b < DIV_W; b++) limit[b] = (b <= int'(code));
  end

  assign atLimit = (divCnt == limit);
  assign adv     = tick & (bypass | atLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (clear)           divCnt <= '0;
    else if (tick && !bypass) divCnt <= atLimit ? '0 : divCnt + 1'b1;
  end
endmodule

// File: rtl/tmr_regctl.sv
module tmr_regctl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanWords,
  output chanStb_t [NUM_CH-1:0]          stb,
  output logic [DATA_W-1:0]              rdData
);
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      stb[c] = '0;
      if (addr == ADDR_W'(OFF_CLK + c * CH_STRIDE)) begin
        stb[c].wrClk = wrEn;
        if (rdEn) stb[c].sel = SEL_CLK;
      end
      if (addr == ADDR_W'(OFF_CNT + c * CH_STRIDE)) begin
        stb[c].wrCnt = wrEn;
        if (rdEn) stb[c].sel = SEL_CNT;
      end
      if (addr == ADDR_W'(OFF_VAL + c * CH_STRIDE)) begin
        if (rdEn) stb[c].sel = SEL_VAL;
      end
      if (addr == ADDR_W'(OFF_INTV + c * CH_STRIDE)) begin
        stb[c].wrIntv = wrEn;
        if (rdEn) stb[c].sel = SEL_INTV;
      end
      if (addr == ADDR_W'(OFF_STAT + c * CH_STRIDE)) begin
        stb[c].rdStat = rdEn;
        if (rdEn) stb[c].sel = SEL_STAT;
      end
      if (addr == ADDR_W'(OFF_EN + c * CH_STRIDE)) begin
        stb[c].wrIrqEn = wrEn;
        if (rdEn) stb[c].sel = SEL_EN;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    for (int c = 0; c < NUM_CH; c++) rdMux = rdMux | chanWords[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  output logic [DATA_W-1:0] rdWord,
  output logic              irq,
  output logic [CNT_W-1:0]  count,
  output logic              flag,
  output logic              halt,
  output logic              mode
);
  logic [CLK_CTL_W-1:0] clkCtl;
  logic [CNT_W-1:0]     intv;
  logic                 irqEn;
  logic                 restart;
  logic                 adv;
  logic                 hit;

  assign restart = stb.wrCnt & wrData[BIT_RESTART];

  tmr_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tickEn & ~halt),
    .clear  (restart | stb.wrClk),
    .bypass (~clkCtl[0]),
    .code   (clkCtl[PRE_W:1]),
    .adv    (adv)
  );

  assign hit = adv & mode & (count == intv) & ~restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCtl <= '0;
      halt   <= 1'b1;
      mode   <= 1'b0;
      intv   <= '0;
      irqEn  <= 1'b0;
    end else begin
      if (stb.wrClk)   clkCtl <= wrData[CLK_CTL_W-1:0];
      if (stb.wrCnt) begin
        halt <= wrData[BIT_HALT];
        mode <= wrData[BIT_MODE];
      end
      if (stb.wrIntv)  intv  <= wrData[CNT_W-1:0];
      if (stb.wrIrqEn) irqEn <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (restart) count <= '0;
    else if (adv)     count <= (mode && count == intv) ? '0 : count + 1'b1;
  end

  // a new hit outranks the clear of a simultaneous status read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flag <= 1'b0;
    else if (hit)        flag <= 1'b1;
    else if (stb.rdStat) flag <= 1'b0;
  end

  assign irq = flag & irqEn;

  always_comb begin
    unique case (stb.sel)
      SEL_CLK:  rdWord = DATA_W'(clkCtl);
      SEL_CNT:  rdWord = DATA_W'({mode, halt});
      SEL_VAL:  rdWord = DATA_W'(count);
      SEL_INTV: rdWord = DATA_W'(intv);
      SEL_STAT: rdWord = DATA_W'(flag);
      SEL_EN:   rdWord = DATA_W'(irqEn);
      default:  rdWord = '0;
    endcase
  end

  if (CNT_W < DATA_W) begin : g_hi
    logic unusedHi;
    assign unusedHi = ^wrData[DATA_W-1:CNT_W];
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] tickEn,
  output logic [NUM_CH-1:0] irq
);
  chanStb_t [NUM_CH-1:0]          stb;
  logic [NUM_CH-1:0][DATA_W-1:0]  chanWords;
  logic [NUM_CH-1:0][CNT_W-1:0]   chCount;
  logic [NUM_CH-1:0]              chFlag;
  logic [NUM_CH-1:0]              chHalt;
  logic [NUM_CH-1:0]              chMode;

  tmr_regctl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .chanWords (chanWords),
    .stb       (stb),
    .rdData    (rdData)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_dp (
      .clk    (clk),
      .rstN   (rstN),
      .stb    (stb[c]),
      .wrData (wrData),
      .tickEn (tickEn[c]),
      .rdWord (chanWords[c]),
      .irq    (irq[c]),
      .count  (chCount[c]),
      .flag   (chFlag[c]),
      .halt   (chHalt[c]),
      .mode   (chMode[c])
    );
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             addr,
  input logic [DATA_W-1:0]             wrData,
  input logic                          wrEn,
  input logic                          rdEn,
  input logic [DATA_W-1:0]             rdData,
  input logic [NUM_CH-1:0]             irq,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chCount,
  input logic [NUM_CH-1:0]             chFlag,
  input logic [NUM_CH-1:0]             chHalt,
  input logic [NUM_CH-1:0]             chMode
);
  logic unusedChk;
  assign unusedChk = ^{rdData[DATA_W-1:1], wrData[DATA_W-1:5], wrData[3:1]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic cntWr;
    assign cntWr = wrEn && addr == ADDR_W'(OFF_CNT + c * CH_STRIDE);

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      chHalt[c] && !cntWr |=> $stable(chCount[c])); // R3

    AST_FREE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      !chMode[c] |=> !$rose(chFlag[c])); // R4

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chFlag[c]) |-> chCount[c] == '0); // R6

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      cntWr && wrData[BIT_RESTART] |=> chCount[c] == '0); // R7

    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rstN)
      rdEn && addr == ADDR_W'(OFF_STAT + c * CH_STRIDE) |=> rdData[0] == $past(chFlag[c])); // R8

    AST_MASK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      wrEn && addr == ADDR_W'(OFF_EN + c * CH_STRIDE) && !wrData[0] |=> !irq[c]); // R10
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrData  (wrData),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .irq     (irq),
  .chCount (chCount),
  .chFlag  (chFlag),
  .chHalt  (chHalt),
  .chMode  (chMode)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam logic [7:0] A_CLK = 8'h00, A_CNT = 8'h0C, A_VAL = 8'h18,
                         A_INTV = 8'h24, A_STAT = 8'h54, A_EN = 8'h60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] rdData;
  logic [NCH-1:0] tickEn = '0;
  logic [NCH-1:0] irq;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit #(.NUM_CH(NCH), .CNT_W(16), .ADDR_W(8), .DATA_W(32)) i_tmr_unit (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .tickEn(tickEn), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read one cycle after its strobe
  always @(posedge clk) armed <= rdEn;
  always @(negedge clk) begin
    if (armed && expQ.size() > 0) check(rdData, expQ.pop_front(), tagQ.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag,
                    input bit withTick = 1'b0);
    @(negedge clk); addr = a; rdEn = 1'b1; tickEn[0] = withTick;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); rdEn = 1'b0; tickEn[0] = 1'b0;
  endtask

  task automatic pulses(input int n);
    @(negedge clk); tickEn[0] = 1'b1;
    repeat (n) @(negedge clk);
    tickEn[0] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check({29'd0, irq}, 32'd0, "R1 irq");
    rd(A_CLK, 0, "R1 clk ctl");
    rd(A_CNT, 1, "R1 cnt ctl");
    rd(A_VAL, 0, "R1 count");
    rd(A_INTV, 0, "R1 interval");
    rd(A_STAT, 0, "R1 status");
    rd(A_EN, 0, "R1 enable");
    // R2 layout and stride
    wr(A_CLK + 4, 32'hFFFF_FFFF);
    rd(A_CLK + 4, 32'h3F, "R2 ch1 clk ctl");
    rd(A_CLK, 0, "R2 ch0 untouched");
    wr(A_CLK + 4, 0);
    wr(A_EN + 8, 32'hFFFF_FFFF);
    rd(A_EN + 8, 1, "R2 ch2 enable");
    wr(A_EN + 8, 0);
    // R3 halted at reset
    pulses(5);
    rd(A_VAL, 0, "R3 halted count");
    // R7 restart and run, free mode
    wr(A_CNT, 32'h10);
    pulses(10);
    rd(A_VAL, 10, "R4 count up");
    rd(A_CNT, 0, "R7 restart bit reads 0");
    wr(A_CNT, 32'h1);
    pulses(4);
    rd(A_VAL, 10, "R3 hold");
    wr(A_CNT, 32'h0);
    pulses(3);
    rd(A_VAL, 13, "R3 resume");
    // R11 ignored writes, unmapped read
    wr(A_VAL, 32'h1234);
    rd(A_VAL, 13, "R11 count write ignored");
    rd(8'h70, 0, "R11 unmapped read");
    // R5 prescaler
    wr(A_CLK, 32'h3);            // on, N=1: divide by 4
    wr(A_CNT, 32'h10);
    pulses(11);
    rd(A_VAL, 2, "R5 div4 partial");
    pulses(1);
    rd(A_VAL, 3, "R5 div4 edge");
    wr(A_CLK, 32'h1);            // on, N=0: divide by 2
    wr(A_CNT, 32'h10);
    pulses(7);
    rd(A_VAL, 3, "R5 div2");
    // R12 clock control write clears divider
    wr(A_CLK, 32'h5);            // divide by 8
    wr(A_CNT, 32'h10);
    pulses(6);
    wr(A_CLK, 32'h5);
    pulses(6);
    rd(A_VAL, 0, "R12 divider cleared");
    pulses(2);
    rd(A_VAL, 1, "R12 advance after 8");
    wr(A_CLK, 0);
    // R6 interval mode
    wr(A_INTV, 4);
    wr(A_CNT, 32'h12);
    pulses(4);
    rd(A_VAL, 4, "R6 at interval");
    rd(A_STAT, 0, "R6 no flag yet");
    pulses(1);
    rd(A_VAL, 0, "R6 back to zero");
    rd(A_STAT, 1, "R6 flag set");
    rd(A_STAT, 0, "R8 status cleared by read");
    // R10 irq gating
    wr(A_EN, 1);
    check({31'd0, irq[0]}, 0, "R10 irq low no flag");
    pulses(5);
    check({31'd0, irq[0]}, 1, "R10 irq high");
    wr(A_EN, 0);
    check({31'd0, irq[0]}, 0, "R10 masked");
    wr(A_EN, 1);
    check({31'd0, irq[0]}, 1, "R10 unmasked");
    rd(A_STAT, 1, "R8 status read");
    check({31'd0, irq[0]}, 0, "R10 irq drops after read");
    // R9 set coincident with read
    wr(A_CNT, 32'h12);
    pulses(4);
    rd(A_STAT, 0, "R9 coincident read old value", 1'b1);
    wr(A_STAT, 0);
    rd(A_STAT, 1, "R9 flag kept, R11 status write ignored");
    rd(A_VAL, 0, "R9 count wrapped");
    wr(A_EN, 0);
    // R4 wrap in free mode
    wr(A_CNT, 32'h10);
    pulses(65535);
    rd(A_VAL, 32'hFFFF, "R4 all ones");
    pulses(1);
    rd(A_VAL, 0, "R4 wrap to zero");
    rd(A_STAT, 0, "R4 no flag in free mode");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule